// File: doc/BRIEF.md
# Masked Set/Clear Output Port

The block owns an eight-bit output latch that software never loads directly. Instead, a write at the "set" address turns on every latch bit whose matching data bit is one. A write at the "clear" address turns off every latch bit whose matching data bit is one. Latch bits that match a zero in the data word keep their value. A processor can therefore drive one pin without knowing the state of the others and without a read-modify-write sequence.

The pins are active low with respect to the latch. A latch bit at one drives its pin low, and a latch bit at zero drives its pin high. Each pin from index 2 upward has a one-bit source selector held in a configuration register. The selector chooses between the inverted latch bit and an alternate internal signal. The counter/timer square wave, for example, arrives on the alternate input of pin 3. The two lowest pins take their selector from an input driven by surrounding mode logic, because their sources are owned elsewhere.

Command classification runs through a named decode: `CMD_IDLE` (no strobe, or an unmapped address), `CMD_SET`, `CMD_CLR` and `CMD_CFG`. The latch moves `CMD_SET` → OR-in and `CMD_CLR` → AND-out. The configuration register moves only on `CMD_CFG`. Every other case holds both registers.

Top module: `opp_port`

## Requirements
- R1: While `rst_n` is low, and on its release, the latch and the configuration register are all zeros. With `low_sel` at zero, `port_pins` therefore reads 8'hFF.
- R2: A strobed write at address 4'hE sets each latch bit whose `wr_data` bit is 1 and leaves every other latch bit unchanged.
- R3: A strobed write at address 4'hF clears each latch bit whose `wr_data` bit is 1 and leaves every other latch bit unchanged.
- R4: A register write sampled at a rising clock edge is visible on the pins right after that edge, and not before it.
- R5: A pin whose source is the latch drives the inverse of its latch bit: latch 1 gives pin 0, and latch 0 gives pin 1.
- R6: A strobed write at address 4'hD loads `wr_data[7:2]` into the selectors of pins 7 to 2. A selector of 1 routes `alt_src[k]` to pin k, and a selector of 0 routes the inverted latch bit. `wr_data[1:0]` of that write has no effect.
- R7: For pins 1 and 0, `low_sel[k]` = 1 routes `alt_src[k]` to the pin, and `low_sel[k]` = 0 routes the inverted latch bit.
- R8: With `wr_stb` low, or with `wr_stb` high at any address other than 4'hD, 4'hE or 4'hF, neither register changes.
- R9: Set and clear writes leave the configuration register unchanged, and configuration writes leave the latch unchanged. A latch change made while a pin shows its alternate source appears once the selector returns to 0.
- R10: A selected alternate source reaches its pin in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 4 | Write address (4'hD config, 4'hE set, 4'hF clear) |
| wr_data | input | 8 | Write data / bit mask |
| alt_src | input | 8 | Alternate source for each pin (bit 3 carries the counter/timer wave) |
| low_sel | input | 2 | Source select for pins 1 and 0 (1 = alternate) |
| port_pins | output | 8 | Output pins |

## Verification
The latch is tried with overlapping set masks, to tell OR-in apart from a plain load. It is tried with clear masks that hit both set and already-clear bits, to tell AND-out apart from a toggle. All-ones and all-zeros masks are also used. Strobe-low writes and writes to unmapped addresses carry all-ones data, so any leak into either register would show on the pins. Alternate inputs are toggled in the middle of a cycle under mixed selector patterns, to tell a same-cycle path apart from a registered one and each pin's routing apart from a neighbour's. The latch is changed while pins are hidden behind their alternate sources and then revealed, to tell true latch retention apart from pin-only state.

// File: rtl/opp_pkg.sv
package opp_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2,
        CMD_CFG  = 2'd3
    } opp_cmd_e;

endpackage

// File: rtl/opp_cmd_decode.sv
module opp_cmd_decode
    import opp_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] ADDR_SET = 'hE,
    parameter logic [ADDR_W-1:0] ADDR_CLR = 'hF,
    parameter logic [ADDR_W-1:0] ADDR_CFG = 'hD
) (
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    output opp_cmd_e          cmd
);

    // Classify one bus write; unmapped addresses fall to CMD_IDLE (R8)
    always_comb begin
        cmd = CMD_IDLE;
        if (wr_stb) begin
            if (wr_addr == ADDR_SET)      cmd = CMD_SET;
            else if (wr_addr == ADDR_CLR) cmd = CMD_CLR;
            else if (wr_addr == ADDR_CFG) cmd = CMD_CFG;
        end
    end

endmodule

// File: rtl/opp_latch.sv
module opp_latch
    import opp_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  opp_cmd_e          cmd,
    input  logic [PORT_W-1:0] mask,
    output logic [PORT_W-1:0] q
);

    logic [PORT_W-1:0] q_nxt;

    // Masked update: ones in the mask act, zeros keep (R2, R3)
    always_comb begin
        q_nxt = q;
        unique case (cmd)
            CMD_SET:  q_nxt = q | mask;
            CMD_CLR:  q_nxt = q & ~mask;
            CMD_CFG,
            CMD_IDLE: q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/opp_cfg_reg.sv
module opp_cfg_reg
    import opp_pkg::*;
#(
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  opp_cmd_e         cmd,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              q <= '0;
        else if (cmd == CMD_CFG) q <= din;
    end

endmodule

// File: rtl/opp_pin_mux.sv
module opp_pin_mux #(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] sel,
    input  logic [PORT_W-1:0] alt,
    output logic [PORT_W-1:0] pins
);

    // One selector per pin; latch path is inverted (R5)
    for (genvar k = 0; k < PORT_W; k++) begin : g_pin
        assign pins[k] = sel[k] ? alt[k] : ~latch_q[k];
    end

endmodule

// File: rtl/opp_port.sv
module opp_port
    import opp_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                PORT_W   = 8,
    parameter int                LOW_N    = 2,
    parameter logic [ADDR_W-1:0] ADDR_SET = 'hE,
    parameter logic [ADDR_W-1:0] ADDR_CLR = 'hF,
    parameter logic [ADDR_W-1:0] ADDR_CFG = 'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PORT_W-1:0] alt_src,
    input  logic [LOW_N-1:0]  low_sel,
    output logic [PORT_W-1:0] port_pins
);

    localparam int CFG_W = PORT_W - LOW_N;

    opp_cmd_e          cmd;
    logic [PORT_W-1:0] latch_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [PORT_W-1:0] pin_sel;

    opp_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .ADDR_SET(ADDR_SET),
        .ADDR_CLR(ADDR_CLR),
        .ADDR_CFG(ADDR_CFG)
    ) u_dec (
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .cmd    (cmd)
    );

    opp_latch #(.PORT_W(PORT_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .mask (wr_data),
        .q    (latch_q)
    );

    opp_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .din  (wr_data[PORT_W-1:LOW_N]),
        .q    (cfg_q)
    );

    // Low pins are steered by external mode logic (R7), upper by cfg (R6)
    assign pin_sel = {cfg_q, low_sel};

    opp_pin_mux #(.PORT_W(PORT_W)) u_mux (
        .latch_q(latch_q),
        .sel    (pin_sel),
        .alt    (alt_src),
        .pins   (port_pins)
    );

endmodule

// File: rtl/opp_port_chk.sv
module opp_port_chk #(
    parameter int                ADDR_W   = 4,
    parameter int                PORT_W   = 8,
    parameter int                LOW_N    = 2,
    parameter logic [ADDR_W-1:0] ADDR_SET = 'hE,
    parameter logic [ADDR_W-1:0] ADDR_CLR = 'hF,
    parameter logic [ADDR_W-1:0] ADDR_CFG = 'hD
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_stb,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [PORT_W-1:0]         wr_data,
    input logic [PORT_W-1:0]         alt_src,
    input logic [LOW_N-1:0]          low_sel,
    input logic [PORT_W-1:0]         port_pins,
    input logic [PORT_W-1:0]         latch_q,
    input logic [PORT_W-LOW_N-1:0]   cfg_q
);

    logic              is_set, is_clr, is_cfg;
    logic [PORT_W-1:0] alt_mask;

    assign is_set   = wr_stb && (wr_addr == ADDR_SET);
    assign is_clr   = wr_stb && (wr_addr == ADDR_CLR);
    assign is_cfg   = wr_stb && (wr_addr == ADDR_CFG);
    assign alt_mask = {cfg_q, low_sel};

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> ((latch_q & $past(wr_data)) == $past(wr_data)));                               // R2
    AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));          // R2
    AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((latch_q & $past(wr_data)) == '0));                                            // R3
    AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));          // R3
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_set || is_clr) |=> $stable(latch_q));                                                 // R8
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cfg |=> $stable(cfg_q));                                                               // R9
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_cfg |=> (cfg_q == $past(wr_data[PORT_W-1:LOW_N])));                                     // R6
    AST_PIN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_pins ^ ~latch_q) & ~alt_mask) == '0);                                               // R5
    AST_PIN_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_pins ^ alt_src) & alt_mask) == '0);                                                 // R10

endmodule

bind opp_port opp_port_chk #(
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W),
    .LOW_N   (LOW_N),
    .ADDR_SET(ADDR_SET),
    .ADDR_CLR(ADDR_CLR),
    .ADDR_CFG(ADDR_CFG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .alt_src  (alt_src),
    .low_sel  (low_sel),
    .port_pins(port_pins),
    .latch_q  (latch_q),
    .cfg_q    (cfg_q)
);

// File: tb/opp_port_bench.sv
module opp_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [3:0] wr_addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] alt_src = 8'h00;
    logic [1:0] low_sel = 2'b00;
    logic [7:0] port_pins;

    int n_tests = 0;
    int n_fail  = 0;
    int m_latch = 0;   // reference latch
    int m_sel   = 0;   // reference selectors for pins 7..2 (bits 7..2)

    always #10 clk = ~clk;   // 50 MHz

    opp_port u_opp_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .alt_src  (alt_src),
        .low_sel  (low_sel),
        .port_pins(port_pins)
    );

    function automatic logic [7:0] expect_pins();
        logic [7:0] e;
        for (int k = 0; k < 8; k++) begin
            bit use_alt;
            use_alt = (k < 2) ? low_sel[k] : m_sel[k];
            e[k] = use_alt ? alt_src[k] : !m_latch[k];
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [7:0] exp_v);
        n_tests++;
        if (port_pins !== exp_v) begin
            n_fail++;
            $display("FAIL %s: port_pins=%h expected=%h", req, port_pins, exp_v);
        end
    endtask

    // Drive after a falling edge, check same-cycle, then after the next rise
    task automatic step(input string req, input logic stb, input logic [3:0] addr,
                        input logic [7:0] data, input logic [7:0] alt, input logic [1:0] lsel);
        wr_stb  = stb;
        wr_addr = addr;
        wr_data = data;
        alt_src = alt;
        low_sel = lsel;
        #2;
        check(req, expect_pins());          // before the edge: old register state (R4)
        @(posedge clk);
        if (stb) begin
            if (addr == 4'hE)      m_latch = m_latch | int'(data);
            else if (addr == 4'hF) m_latch = m_latch & ~int'(data);
            else if (addr == 4'hD) m_sel   = int'(data) & 8'hFC;
        end
        @(negedge clk);
        check(req, expect_pins());
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1", 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 8'hFF);

        // R2 / R4 / R5: set masks accumulate
        step("R2", 1'b1, 4'hE, 8'hA5, 8'h00, 2'b00);
        check("R5", 8'h5A);
        step("R2", 1'b1, 4'hE, 8'h0F, 8'h00, 2'b00);
        check("R2", 8'h50);
        // R3: clear masks
        step("R3", 1'b1, 4'hF, 8'h81, 8'h00, 2'b00);
        check("R3", 8'hD1);
        step("R3", 1'b1, 4'hF, 8'h00, 8'h00, 2'b00);
        check("R3", 8'hD1);
        step("R2", 1'b1, 4'hE, 8'hFF, 8'h00, 2'b00);
        check("R2", 8'h00);
        step("R3", 1'b1, 4'hF, 8'hFF, 8'h00, 2'b00);
        check("R3", 8'hFF);
        step("R4", 1'b1, 4'hE, 8'h3C, 8'h00, 2'b00);
        check("R4", 8'hC3);

        // R8: strobe low, unmapped addresses
        step("R8", 1'b0, 4'hE, 8'hFF, 8'h00, 2'b00);
        step("R8", 1'b0, 4'hF, 8'hFF, 8'h00, 2'b00);
        step("R8", 1'b0, 4'hD, 8'hFF, 8'h00, 2'b00);
        step("R8", 1'b1, 4'h3, 8'hFF, 8'h00, 2'b00);
        step("R8", 1'b1, 4'hC, 8'hFF, 8'h00, 2'b00);
        check("R8", 8'hC3);

        // R6: selectors for upper pins, low config bits ignored
        step("R6", 1'b1, 4'hD, 8'h0B, 8'hF0, 2'b00);
        check("R6", 8'hC3);
        step("R6", 1'b1, 4'hD, 8'hA8, 8'hFF, 2'b00);
        check("R6", 8'hEB);
        // R10: alternate inputs pass through in the same cycle
        step("R10", 1'b0, 4'h0, 8'h00, 8'h00, 2'b00);
        check("R10", 8'h43);
        step("R10", 1'b0, 4'h0, 8'h00, 8'h08, 2'b00);
        check("R10", 8'h4B);
        // R7: low pins follow low_sel
        step("R7", 1'b0, 4'h0, 8'h00, 8'h01, 2'b01);
        check("R7", 8'h43);
        step("R7", 1'b0, 4'h0, 8'h00, 8'h01, 2'b10);
        check("R7", 8'h41);
        step("R7", 1'b0, 4'h0, 8'h00, 8'h02, 2'b11);
        check("R7", 8'h42);

        // R9: hidden latch change, then reveal
        step("R9", 1'b1, 4'hD, 8'hFC, 8'h55, 2'b11);
        check("R9", 8'h55);
        step("R9", 1'b1, 4'hF, 8'hFF, 8'h55, 2'b11);
        check("R9", 8'h55);
        step("R9", 1'b1, 4'hE, 8'h90, 8'h55, 2'b11);
        check("R9", 8'h55);
        step("R9", 1'b1, 4'hD, 8'h03, 8'h55, 2'b00);
        check("R9", 8'h6F);
        step("R5", 1'b1, 4'hF, 8'h10, 8'h00, 2'b00);
        check("R5", 8'h7F);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule